// File: doc/BRIEF.md
# Tone-Pair Guard-Time Steering and Key Latch

This block sits behind a dual-tone frequency detector. The detector reports a single "signal condition" flag, together with the row index and column index of the tone pair it has recognised. The block decides when that flag has been valid long enough to count as a keypress. It also decides when the flag has been gone long enough to count as the pause between two digits.

Both decisions come from one run-length counter. The counter replaces an analogue RC timing network, and it uses two programmable guard limits that are counted in clock ticks. When a digit is accepted, the block converts the row and column into the 4-bit key code used on the telephone keypad. It latches that code and then raises a steering flag one cycle later. The latched code drives a 4-bit bus. The bus has an enable that models a three-state driver: when the bus is disabled it reads as zero, and a separate flag reports whether it is driven.

A host or sequencer watches the steering flag for a rising edge and reads the code from the bus. The code stays valid through the pause that follows, until the next digit is accepted. The guard limits are input ports, so a system can change the acquisition time and the release time. Writing zero to either limit selects the built-in default for that limit. The defaults give roughly 32 ms of present guard and 20 ms of absent guard at a 3.579545 MHz clock.

Top module: `guard_steer_top`

## Requirements
- R1: A digit is accepted only when `sig_det` is high at P consecutive rising clock edges, where P is the effective present limit. The key latch takes the code at the P-th edge, and `steer` rises at the edge after that.
- R2: A burst with fewer than P consecutive high samples changes neither the latched code nor `steer`. This holds even when two short bursts are split by a single low sample.
- R3: Once `steer` is high, it falls at the edge where `sig_det` has been low at A consecutive edges, where A is the effective absent limit. Counting the low samples begins at the edge after `steer` rises.
- R4: A dropout with fewer than A consecutive low samples does not end the digit. In that case `steer` stays high, the code stays latched, and the low-run count restarts when `sig_det` returns.
- R5: The latched code is visible on `key_bus` one cycle before `steer` rises.
- R6: After a digit is released, the latched code persists unchanged until the next digit is accepted.
- R7: The `bus_drv` output follows `out_en` one cycle later. While `bus_drv` is 0, `key_bus` reads 0000. While `bus_drv` is 1, `key_bus` shows the latched code. A digit is still accepted and latched while the bus is disabled.
- R8: Row index 0..3 stands for 697/770/852/941 Hz, and column index 0..3 stands for 1209/1336/1477/1633 Hz. The code is 0001..1001 for keys 1..9 (row-major over columns 0..2 of rows 0..2), 1010 for key 0 (row 3, column 1), 1011 for * (row 3, column 0) and 1100 for # (row 3, column 2). Column 3 gives 1101, 1110 and 1111 for rows 0..2 and 0000 for row 3.
- R9: An `on_ticks` or `off_ticks` value of zero selects the parameter default (`DEF_PRESENT` or `DEF_ABSENT`). A limit value takes effect one cycle after it is applied.
- R10: While `rst` is high, the latch holds 0000, `steer` is low, `bus_drv` is low and the run counter is zero.
- R11: While a digit is held, changes on `row_idx` and `col_idx` do not alter the latched code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_det | input | 1 | Signal-condition flag from the detector |
| row_idx | input | 2 | Low-group tone index |
| col_idx | input | 2 | High-group tone index |
| on_ticks | input | CW | Present guard limit in ticks (0 selects default) |
| off_ticks | input | CW | Absent guard limit in ticks (0 selects default) |
| out_en | input | 1 | Bus enable request |
| key_bus | output | 4 | Latched key code, zero when not driven |
| bus_drv | output | 1 | High when the bus is driven |
| steer | output | 1 | Delayed steering flag: a digit is registered |

## Verification
The bench drives inputs on falling edges and counts rising edges. The code therefore shows on the bus after the P-th high edge. `steer` rises one edge later. `steer` falls on the A-th low edge counted after its rise, and `bus_drv` tracks `out_en` after one edge. Every check is sampled at the falling edge that follows the edge where the result is due. Each check also looks at the edge before that one, so a late or early result is caught. Limit changes get one settling edge before a tone starts.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_HELD = 2'd2
  } steer_state_e;

  localparam int KEY_W = 4;
  localparam int IDX_W = 2;

  // Keypad code from tone indices (R8), computed arithmetically.
  function automatic logic [KEY_W-1:0] key_code(input logic [IDX_W-1:0] row,
                                                input logic [IDX_W-1:0] col);
    logic [KEY_W-1:0] r4;
    logic [KEY_W-1:0] c4;
    logic [KEY_W-1:0] res;
    r4 = {2'b00, row};
    c4 = {2'b00, col};
    if (col == 2'd3) begin
      res = 4'd13 + r4;            // wraps to 0000 for the last row
    end else if (row != 2'd3) begin
      res = r4 * 4'd3 + c4 + 4'd1;
    end else begin
      case (col)
        2'd0:    res = 4'd11;
        2'd1:    res = 4'd10;
        default: res = 4'd12;
      endcase
    end
    return res;
  endfunction

endpackage

// File: rtl/guard_limit.sv
module guard_limit #(
  parameter int CW  = 18,
  parameter int DEF = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] raw_i,
  output logic [CW-1:0] lim_o
);
  localparam logic [CW-1:0] DEF_V = CW'(DEF);

  always_ff @(posedge clk) begin
    if (rst) lim_o <= DEF_V;
    else     lim_o <= (raw_i == '0) ? DEF_V : raw_i;
  end

  p_limit_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
    (lim_o != '0));
endmodule

// File: rtl/key_encoder.sv
module key_encoder
  import dtmf_steer_pkg::*;
(
  input  logic [IDX_W-1:0] row_i,
  input  logic [IDX_W-1:0] col_i,
  output logic [KEY_W-1:0] code_o
);
  always_comb code_o = key_code(row_i, col_i);
endmodule

// File: rtl/guard_fsm.sv
module guard_fsm
  import dtmf_steer_pkg::*;
#(
  parameter int CW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sig_det,
  input  logic [CW-1:0] on_limit,
  input  logic [CW-1:0] off_limit,
  output logic          load_o,
  output logic          steer_o
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  steer_state_e  st_q;
  logic [CW-1:0] run_q;
  logic [CW-1:0] run_inc;

  assign run_inc = run_q + ONE;

  always_comb load_o = (st_q == ST_IDLE) && sig_det && (run_inc >= on_limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      run_q   <= '0;
      steer_o <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (!sig_det) begin
            run_q <= '0;
          end else if (run_inc >= on_limit) begin
            st_q  <= ST_ARM;
            run_q <= '0;
          end else begin
            run_q <= run_inc;
          end
        end
        ST_ARM: begin
          steer_o <= 1'b1;
          st_q    <= ST_HELD;
          run_q   <= '0;
        end
        ST_HELD: begin
          if (sig_det) begin
            run_q <= '0;
          end else if (run_inc >= off_limit) begin
            steer_o <= 1'b0;
            st_q    <= ST_IDLE;
            run_q   <= '0;
          end else begin
            run_q <= run_inc;
          end
        end
        default: begin
          st_q    <= ST_IDLE;
          run_q   <= '0;
          steer_o <= 1'b0;
        end
      endcase
    end
  end

  // R1: a present run never reaches the limit without moving on
  p_run_below_on_r1: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> (run_q < on_limit));
  // R3: steering flag only while a digit is held
  p_steer_in_held_r3: assert property (@(posedge clk) disable iff (rst)
    steer_o |-> (st_q == ST_HELD));
  // R3: release only after an absent sample
  p_release_on_gap_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(steer_o) |-> $past(!sig_det));
endmodule

// File: rtl/code_latch.sv
module code_latch
  import dtmf_steer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [KEY_W-1:0] code_i,
  input  logic             out_en,
  output logic [KEY_W-1:0] latch_o,
  output logic             drv_o,
  output logic [KEY_W-1:0] bus_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_o <= '0;
      drv_o   <= 1'b0;
    end else begin
      drv_o <= out_en;
      if (load_i) latch_o <= code_i;
    end
  end

  assign bus_o = drv_o ? latch_o : '0;

  // R6: the code changes only on a load
  p_hold_without_load_r6: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(latch_o));
endmodule

// File: rtl/guard_steer_top.sv
module guard_steer_top
  import dtmf_steer_pkg::*;
#(
  parameter int CW          = 18,
  parameter int DEF_PRESENT = 114545,
  parameter int DEF_ABSENT  = 71591
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sig_det,
  input  logic [1:0]    row_idx,
  input  logic [1:0]    col_idx,
  input  logic [CW-1:0] on_ticks,
  input  logic [CW-1:0] off_ticks,
  input  logic          out_en,
  output logic [3:0]    key_bus,
  output logic          bus_drv,
  output logic          steer
);
  localparam int NLIM = 2;

  logic [CW-1:0]    lim_raw [NLIM];
  logic [CW-1:0]    lim_eff [NLIM];
  logic             load;
  logic [KEY_W-1:0] code;
  logic [KEY_W-1:0] latch_q;

  assign lim_raw[0] = on_ticks;
  assign lim_raw[1] = off_ticks;

  for (genvar gi = 0; gi < NLIM; gi++) begin : g_lim
    guard_limit #(
      .CW (CW),
      .DEF((gi == 0) ? DEF_PRESENT : DEF_ABSENT)
    ) u_lim (
      .clk  (clk),
      .rst  (rst),
      .raw_i(lim_raw[gi]),
      .lim_o(lim_eff[gi])
    );
  end

  key_encoder u_enc (
    .row_i (row_idx),
    .col_i (col_idx),
    .code_o(code)
  );

  guard_fsm #(.CW(CW)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .sig_det  (sig_det),
    .on_limit (lim_eff[0]),
    .off_limit(lim_eff[1]),
    .load_o   (load),
    .steer_o  (steer)
  );

  code_latch u_latch (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .code_i (code),
    .out_en (out_en),
    .latch_o(latch_q),
    .drv_o  (bus_drv),
    .bus_o  (key_bus)
  );

  // R5: the latch was loaded one cycle before the steering flag rose
  p_data_before_steer_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(steer) |-> $past(load, 2));
  // R1: a rise follows a present sample
  p_rise_after_signal_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(steer) |-> $past(sig_det, 2));
  // R11: no load while a digit is held
  p_no_reload_held_r11: assert property (@(posedge clk) disable iff (rst)
    steer |-> !load);
endmodule

// File: tb/guard_steer_top_tb_top.sv
module guard_steer_top_tb_top;
  localparam int CW = 18;
  localparam int P  = 5;
  localparam int A  = 4;
  localparam int DP = 6;
  localparam int DA = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sig_det = 1'b0;
  logic [1:0]    row_idx = 2'd0;
  logic [1:0]    col_idx = 2'd0;
  logic [CW-1:0] on_ticks = CW'(P);
  logic [CW-1:0] off_ticks = CW'(A);
  logic          out_en = 1'b1;
  logic [3:0]    key_bus;
  logic          bus_drv;
  logic          steer;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  guard_steer_top #(.CW(CW), .DEF_PRESENT(DP), .DEF_ABSENT(DA)) dut_i (
    .clk(clk), .rst(rst), .sig_det(sig_det), .row_idx(row_idx), .col_idx(col_idx),
    .on_ticks(on_ticks), .off_ticks(off_ticks), .out_en(out_en),
    .key_bus(key_bus), .bus_drv(bus_drv), .steer(steer)
  );

  function automatic logic [3:0] exp_code(input logic [1:0] r, input logic [1:0] c);
    case ({r, c})
      4'h0: return 4'd1;  4'h1: return 4'd2;  4'h2: return 4'd3;  4'h3: return 4'd13;
      4'h4: return 4'd4;  4'h5: return 4'd5;  4'h6: return 4'd6;  4'h7: return 4'd14;
      4'h8: return 4'd7;  4'h9: return 4'd8;  4'hA: return 4'd9;  4'hB: return 4'd15;
      4'hC: return 4'd11; 4'hD: return 4'd10; 4'hE: return 4'd12; default: return 4'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic tone(input logic [1:0] r, input logic [1:0] c, input int n);
    row_idx = r; col_idx = c; sig_det = 1'b1;
    repeat (n) @(negedge clk);
    sig_det = 1'b0;
  endtask

  // steer: 1 edge to rise, then na-1 held, falls at the na-th low edge
  task automatic release_seq(input int na, input string req);
    @(negedge clk);
    check(steer == 1'b1, req, steer, 1);
    repeat (na - 1) @(negedge clk);
    check(steer == 1'b1, req, steer, 1);
    @(negedge clk);
    check(steer == 1'b0, req, steer, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(key_bus == 4'd0, "R10 bus", key_bus, 0);
    check(steer == 1'b0, "R10 steer", steer, 0);
    check(bus_drv == 1'b0, "R10 drv", bus_drv, 0);
    rst = 1'b0;
    @(negedge clk);
    check(bus_drv == 1'b1, "R7 drv follows", bus_drv, 1);
    check(key_bus == 4'd0, "R10 latch clear", key_bus, 0);
  endtask

  task automatic t_register;
    tone(2'd0, 2'd0, P);
    check(key_bus == 4'd1, "R1 code at P-th edge", key_bus, 1);
    check(steer == 1'b0, "R5 data before steer", steer, 0);
    release_seq(A, "R3 release timing");
  endtask

  task automatic t_burst;
    tone(2'd1, 2'd1, P - 1);
    repeat (6) begin
      @(negedge clk);
      check(steer == 1'b0, "R2 short burst steer", steer, 0);
    end
    check(key_bus == 4'd1, "R2 short burst code", key_bus, 1);
    tone(2'd1, 2'd1, P - 1);
    @(negedge clk);
    tone(2'd1, 2'd1, P - 1);
    repeat (3) @(negedge clk);
    check(steer == 1'b0, "R2 split burst steer", steer, 0);
    check(key_bus == 4'd1, "R2 split burst code", key_bus, 1);
  endtask

  task automatic t_dropout;
    tone(2'd2, 2'd2, P + 2);
    repeat (A - 1) @(negedge clk);
    check(steer == 1'b1, "R4 dropout steer", steer, 1);
    row_idx = 2'd3; col_idx = 2'd3; sig_det = 1'b1;
    repeat (3) @(negedge clk);
    check(steer == 1'b1, "R4 after dropout", steer, 1);
    check(key_bus == 4'd9, "R11 held code", key_bus, 9);
    sig_det = 1'b0;
    repeat (A - 1) @(negedge clk);
    check(steer == 1'b1, "R4 count restarted", steer, 1);
    @(negedge clk);
    check(steer == 1'b0, "R3 final release", steer, 0);
    repeat (20) @(negedge clk);
    check(key_bus == 4'd9, "R6 code persists", key_bus, 9);
  endtask

  task automatic t_keymap;
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        tone(r[1:0], c[1:0], P);
        check(key_bus == exp_code(r[1:0], c[1:0]), "R8 key code", key_bus,
              exp_code(r[1:0], c[1:0]));
        repeat (A + 3) @(negedge clk);
        check(steer == 1'b0, "R3 released", steer, 0);
      end
    end
  endtask

  task automatic t_bus;
    out_en = 1'b0;
    @(negedge clk);
    check(bus_drv == 1'b0, "R7 drv low", bus_drv, 0);
    check(key_bus == 4'd0, "R7 dark bus", key_bus, 0);
    tone(2'd0, 2'd1, P);
    @(negedge clk);
    check(steer == 1'b1, "R7 accept while dark", steer, 1);
    check(key_bus == 4'd0, "R7 dark bus held", key_bus, 0);
    out_en = 1'b1;
    @(negedge clk);
    check(key_bus == 4'd2, "R7 bus shows code", key_bus, 2);
    repeat (A + 2) @(negedge clk);
  endtask

  task automatic t_defaults;
    on_ticks = '0; off_ticks = '0;
    repeat (2) @(negedge clk);
    tone(2'd2, 2'd0, DP - 1);
    repeat (2) @(negedge clk);
    check(steer == 1'b0, "R9 default present not met", steer, 0);
    check(key_bus == 4'd2, "R9 code unchanged", key_bus, 2);
    tone(2'd2, 2'd0, DP);
    check(key_bus == 4'd7, "R9 default present", key_bus, 7);
    check(steer == 1'b0, "R5 steer lags", steer, 0);
    release_seq(DA, "R9 default absent");
  endtask

  initial begin
    t_reset();
    t_register();
    t_burst();
    t_dropout();
    t_keymap();
    t_bus();
    t_defaults();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule